// File: doc/BRIEF.md
# SDRAM Bank Timing Tracker

This block follows the state of a single SDRAM bank on behalf of a memory controller. It tells the controller which command may go out this cycle. It accepts one command at a time, with a valid strobe, a 2-bit command code and a row address. From the accepted commands it tracks whether the bank is open, which row is open, and how many cycles remain on each spacing rule.

The four spacing values are inputs, given in whole clock cycles:
- activate-to-column delay
- read latency
- minimum page-open time
- precharge time

The controller may change them while the bank is idle. For every accepted read, the block also produces a data-valid pulse train. The train starts after the read latency and lasts one burst.

A command issued while its permission flag is low is refused. It is flagged on a combinational violation output in the same cycle and leaves the bank state untouched. Refresh, the data path and the pin-level DRAM interface belong to other blocks.

Top module: `sdram_bank_tracker`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, the bank is closed, `rd_valid_o` is low and `act_ok_o` is high. Every spacing timer starts out expired.
- R2: A read or write is permitted only when at least `trcd_i` cycles have passed since the accepted activate. With `trcd_i`=2, an activate accepted in cycle t allows a column command in cycle t+2 and not before.
- R3: A read accepted in cycle t drives `rd_valid_o` high in cycles t+`cas_lat_i` through t+`cas_lat_i`+BURST_LEN-1. These are exactly BURST_LEN consecutive cycles. `cas_lat_i` is at least 1.
- R4: A precharge is permitted only when at least `tras_i` cycles have passed since the accepted activate.
- R5: A precharge is also withheld until the last data-valid cycle of the current burst has passed.
- R6: An accepted precharge closes the bank. A new activate is permitted no earlier than `trp_i` cycles after the precharge.
- R7: Two accepted activates are always at least `tras_i`+`trp_i` cycles apart.
- R8: The command codes are: 0 activate, 1 read, 2 write, 3 precharge. A command with `cmd_valid_i` high whose permission flag is low raises `violation_o` in that cycle. It changes neither the open status nor the open row.
- R9: After an accepted activate, `bank_open_o` is high from the next cycle on. `open_row_o` then shows the row given with that activate.
- R10: Activate is permitted only on a closed bank. Read, write and precharge are permitted only on an open bank. Read and write are withheld while a read burst is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 2 | Command code (0 act, 1 read, 2 write, 3 precharge) |
| row_i | input | ROW_W | Row address for activate |
| trcd_i | input | CNT_W | Activate-to-column delay, cycles |
| cas_lat_i | input | CNT_W | Read latency, cycles |
| tras_i | input | CNT_W | Minimum page-open time, cycles |
| trp_i | input | CNT_W | Precharge time, cycles |
| act_ok_o | output | 1 | Activate permitted this cycle |
| rd_ok_o | output | 1 | Read permitted this cycle |
| wr_ok_o | output | 1 | Write permitted this cycle |
| pre_ok_o | output | 1 | Precharge permitted this cycle |
| violation_o | output | 1 | Strobed command refused |
| bank_open_o | output | 1 | Bank holds an open row |
| open_row_o | output | ROW_W | Row currently open |
| rd_valid_o | output | 1 | Read data word present |

## Verification
The bench builds the block with ROW_W=8, CNT_W=4 and BURST_LEN=4. It reprograms the timing inputs between phases.

With tRAS=5 and read latency 2, a read burst ends after the page-open time has already expired. This exposes the case where only the pending burst holds back a precharge.

A phase with tRAS=3 and tRP=3 issues commands at the earliest permitted cycle. That lets the spacing of the activate-precharge-activate sequence be measured exactly. A latency of 3 then shifts the data-valid train, to show that it follows the input and not a fixed delay.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  typedef enum logic [1:0] {
    SBT_ACT = 2'd0,
    SBT_RD  = 2'd1,
    SBT_WR  = 2'd2,
    SBT_PRE = 2'd3
  } sbt_cmd_e;

  // timer slots
  localparam int unsigned TMR_RCD = 0;
  localparam int unsigned TMR_RAS = 1;
  localparam int unsigned TMR_RP  = 2;
  localparam int unsigned TMR_RC  = 3;
  localparam int unsigned TMR_NUM = 4;
endpackage

// File: rtl/sbt_delay_cnt.sv
module sbt_delay_cnt #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sbt_burst_gen.sv
module sbt_burst_gen #(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cl_i,
  output logic             busy_o,
  output logic             valid_o
);
  localparam int unsigned BW = CNT_W + $clog2(BURST_LEN + 1) + 1;

  logic [BW-1:0] cnt_q;
  logic [BW-1:0] load_val;

  // remaining cycles until burst end; data window is the last BURST_LEN counts
  assign load_val = BW'(cl_i) + BW'(BURST_LEN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o  = (cnt_q != '0);
  assign valid_o = busy_o && (cnt_q <= BW'(BURST_LEN));
endmodule

// File: rtl/sbt_cmd_gate.sv
module sbt_cmd_gate
  import sbt_pkg::*;
(
  input  logic     cmd_valid_i,
  input  sbt_cmd_e cmd_i,
  input  logic     bank_open_i,
  input  logic     rcd_done_i,
  input  logic     ras_done_i,
  input  logic     rp_done_i,
  input  logic     rc_done_i,
  input  logic     burst_busy_i,
  output logic     act_ok_o,
  output logic     rd_ok_o,
  output logic     wr_ok_o,
  output logic     pre_ok_o,
  output logic     acc_act_o,
  output logic     acc_rd_o,
  output logic     acc_pre_o,
  output logic     viol_o
);
  logic cmd_ok;

  always_comb begin
    act_ok_o = !bank_open_i && rp_done_i && rc_done_i;
    rd_ok_o  = bank_open_i && rcd_done_i && !burst_busy_i;
    wr_ok_o  = bank_open_i && rcd_done_i && !burst_busy_i;
    pre_ok_o = bank_open_i && ras_done_i && !burst_busy_i;
    unique case (cmd_i)
      SBT_ACT: cmd_ok = act_ok_o;
      SBT_RD:  cmd_ok = rd_ok_o;
      SBT_WR:  cmd_ok = wr_ok_o;
      default: cmd_ok = pre_ok_o;
    endcase
    acc_act_o = cmd_valid_i && cmd_ok && (cmd_i == SBT_ACT);
    acc_rd_o  = cmd_valid_i && cmd_ok && (cmd_i == SBT_RD);
    acc_pre_o = cmd_valid_i && cmd_ok && (cmd_i == SBT_PRE);
    viol_o    = cmd_valid_i && !cmd_ok;
  end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter int unsigned ROW_W     = 13,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [CNT_W-1:0] trcd_i,
  input  logic [CNT_W-1:0] cas_lat_i,
  input  logic [CNT_W-1:0] tras_i,
  input  logic [CNT_W-1:0] trp_i,
  output logic             act_ok_o,
  output logic             rd_ok_o,
  output logic             wr_ok_o,
  output logic             pre_ok_o,
  output logic             violation_o,
  output logic             bank_open_o,
  output logic [ROW_W-1:0] open_row_o,
  output logic             rd_valid_o
);
  localparam int unsigned TW = CNT_W + 1;

  logic             acc_act, acc_rd, acc_pre;
  logic             burst_busy;
  logic [TMR_NUM-1:0] tmr_load, tmr_done;
  logic [TW-1:0]    tmr_val [TMR_NUM];
  logic             open_q;
  logic [ROW_W-1:0] row_q;

  function automatic logic [TW-1:0] less_one(input logic [TW-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  // a timer loaded with N-1 at the accepting edge permits the command N cycles later
  always_comb begin
    tmr_val[TMR_RCD]  = less_one(TW'(trcd_i));
    tmr_val[TMR_RAS]  = less_one(TW'(tras_i));
    tmr_val[TMR_RP]   = less_one(TW'(trp_i));
    tmr_val[TMR_RC]   = less_one(TW'(tras_i) + TW'(trp_i));
    tmr_load[TMR_RCD] = acc_act;
    tmr_load[TMR_RAS] = acc_act;
    tmr_load[TMR_RP]  = acc_pre;
    tmr_load[TMR_RC]  = acc_act;
  end

  for (genvar g = 0; g < TMR_NUM; g++) begin : g_tmr
    sbt_delay_cnt #(.W(TW)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (tmr_load[g]),
      .val_i  (tmr_val[g]),
      .done_o (tmr_done[g])
    );
  end

  sbt_burst_gen #(.CNT_W(CNT_W), .BURST_LEN(BURST_LEN)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (acc_rd),
    .cl_i    (cas_lat_i),
    .busy_o  (burst_busy),
    .valid_o (rd_valid_o)
  );

  sbt_cmd_gate u_gate (
    .cmd_valid_i  (cmd_valid_i),
    .cmd_i        (sbt_cmd_e'(cmd_i)),
    .bank_open_i  (open_q),
    .rcd_done_i   (tmr_done[TMR_RCD]),
    .ras_done_i   (tmr_done[TMR_RAS]),
    .rp_done_i    (tmr_done[TMR_RP]),
    .rc_done_i    (tmr_done[TMR_RC]),
    .burst_busy_i (burst_busy),
    .act_ok_o     (act_ok_o),
    .rd_ok_o      (rd_ok_o),
    .wr_ok_o      (wr_ok_o),
    .pre_ok_o     (pre_ok_o),
    .acc_act_o    (acc_act),
    .acc_rd_o     (acc_rd),
    .acc_pre_o    (acc_pre),
    .viol_o       (violation_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (acc_act) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (acc_pre) begin
      open_q <= 1'b0;
    end
  end

  assign bank_open_o = open_q;
  assign open_row_o  = row_q;
endmodule

// File: rtl/sbt_bank_checker.sv
module sbt_bank_checker #(
  parameter int unsigned ROW_W     = 13,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned BURST_LEN = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [1:0]       cmd_i,
  input logic [ROW_W-1:0] row_i,
  input logic [CNT_W-1:0] trcd_i,
  input logic [CNT_W-1:0] cas_lat_i,
  input logic [CNT_W-1:0] tras_i,
  input logic [CNT_W-1:0] trp_i,
  input logic             act_ok_o,
  input logic             rd_ok_o,
  input logic             wr_ok_o,
  input logic             pre_ok_o,
  input logic             violation_o,
  input logic             bank_open_o,
  input logic [ROW_W-1:0] open_row_o,
  input logic             rd_valid_o
);
  localparam int unsigned SW = CNT_W + 2;
  localparam int unsigned RW = $clog2(BURST_LEN + 1) + 1;

  logic          go_act, go_pre, go_col;
  logic [SW-1:0] since_act, since_pre;
  logic [RW-1:0] run_q;

  assign go_act = cmd_valid_i && !violation_o && (cmd_i == 2'd0);
  assign go_pre = cmd_valid_i && !violation_o && (cmd_i == 2'd3);
  assign go_col = cmd_valid_i && !violation_o && (cmd_i == 2'd1 || cmd_i == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act <= '1;
      since_pre <= '1;
      run_q     <= '0;
    end else begin
      if (go_act)              since_act <= SW'(1);
      else if (since_act != '1) since_act <= since_act + 1'b1;
      if (go_pre)              since_pre <= SW'(1);
      else if (since_pre != '1) since_pre <= since_pre + 1'b1;
      run_q <= rd_valid_o ? run_q + 1'b1 : '0;
    end
  end

  assert_col_after_rcd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_col |-> (since_act >= SW'(trcd_i)));

  assert_valid_run_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (run_q < RW'(BURST_LEN)));

  assert_valid_run_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_valid_o && run_q != '0) |-> (run_q == RW'(BURST_LEN)));

  assert_pre_after_ras_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_pre |-> (since_act >= SW'(tras_i)));

  assert_pre_no_burst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_pre |-> !rd_valid_o);

  assert_act_after_rp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_act |-> (since_pre >= SW'(trp_i)));

  assert_act_spacing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_act |-> (since_act >= SW'(tras_i) + SW'(trp_i)));

  assert_refused_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    violation_o |=> ($stable(bank_open_o) && $stable(open_row_o)));

  assert_open_after_act_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_act |=> (bank_open_o && open_row_o == $past(row_i)));

  assert_ok_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_ok_o && (rd_ok_o || wr_ok_o || pre_ok_o)));
endmodule

bind sdram_bank_tracker sbt_bank_checker #(
  .ROW_W(ROW_W), .CNT_W(CNT_W), .BURST_LEN(BURST_LEN)
) u_sbt_chk (.*);

// File: tb/tb_sdram_bank_tracker.sv
module tb_sdram_bank_tracker;
  localparam int unsigned ROW_W = 8;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned BL    = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [1:0]       cmd = 2'd0;
  logic [ROW_W-1:0] row = '0;
  logic [CNT_W-1:0] trcd = 4'd2, cl = 4'd2, tras = 4'd5, trp = 4'd2;
  logic act_ok, rd_ok, wr_ok, pre_ok, viol, bopen, rdv;
  logic [ROW_W-1:0] orow;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sdram_bank_tracker #(.ROW_W(ROW_W), .CNT_W(CNT_W), .BURST_LEN(BL)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .row_i(row),
    .trcd_i(trcd), .cas_lat_i(cl), .tras_i(tras), .trp_i(trp),
    .act_ok_o(act_ok), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .pre_ok_o(pre_ok),
    .violation_o(viol), .bank_open_o(bopen), .open_row_o(orow), .rd_valid_o(rdv)
  );

  typedef struct packed {
    logic       v;
    logic [1:0] c;
    logic [7:0] r;
    logic       e_act, e_rd, e_wr, e_pre, e_viol, e_val, e_open;
    logic [7:0] e_row;
  } vec_t;

  // trcd=2 cl=2 tras=5 trp=2, one row per cycle
  localparam vec_t TBL [16] = '{
    '{1'b0, 2'd0, 8'd0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0},
    '{1'b1, 2'd1, 8'd0, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'd0},
    '{1'b1, 2'd0, 8'd5, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd0},
    '{1'b1, 2'd1, 8'd0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 8'd5},
    '{1'b1, 2'd1, 8'd0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 8'd5},
    '{1'b1, 2'd3, 8'd0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 8'd5},
    '{1'b0, 2'd0, 8'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 8'd5},
    '{1'b1, 2'd3, 8'd0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 8'd5},
    '{1'b0, 2'd0, 8'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 8'd5},
    '{1'b0, 2'd0, 8'd0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 8'd5},
    '{1'b1, 2'd3, 8'd0, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 8'd5},
    '{1'b1, 2'd0, 8'd9, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'd5},
    '{1'b1, 2'd0, 8'd9, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd5},
    '{1'b1, 2'd2, 8'd0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 8'd9},
    '{1'b1, 2'd2, 8'd0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 8'd9},
    '{1'b0, 2'd0, 8'd0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 8'd9}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic drive(input logic v, input logic [1:0] c, input logic [ROW_W-1:0] r);
    @(posedge clk); #1;
    cmd_valid = v; cmd = c; row = r;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    int a0, p0, a1, first_v, run;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 open in reset", bopen, 0);
    chk("R1 act_ok in reset", act_ok, 1);
    chk("R1 rd_valid in reset", rdv, 0);
    #1 rst_ni = 1'b1;

    for (int i = 0; i < 16; i++) begin
      drive(TBL[i].v, TBL[i].c, TBL[i].r[ROW_W-1:0]);
      @(negedge clk);
      chk($sformatf("R6/R10 act_ok row%0d", i), act_ok, TBL[i].e_act);
      chk($sformatf("R2/R10 rd_ok row%0d", i), rd_ok, TBL[i].e_rd);
      chk($sformatf("R2/R10 wr_ok row%0d", i), wr_ok, TBL[i].e_wr);
      chk($sformatf("R4/R5 pre_ok row%0d", i), pre_ok, TBL[i].e_pre);
      chk($sformatf("R8 violation row%0d", i), viol, TBL[i].e_viol);
      chk($sformatf("R3 rd_valid row%0d", i), rdv, TBL[i].e_val);
      chk($sformatf("R9 open row%0d", i), bopen, TBL[i].e_open);
      if (TBL[i].e_open) chk($sformatf("R9 open_row row%0d", i), orow, TBL[i].e_row);
    end

    // R1: reset while open
    drive(1'b0, 2'd0, '0);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 reset closes bank", bopen, 0);
    chk("R1 reset act_ok", act_ok, 1);
    @(posedge clk); #1 rst_ni = 1'b1;

    // R4 R6 R7: earliest-issue spacing with tras=3 trp=3
    tras = 4'd3; trp = 4'd3;
    a0 = -1; p0 = -1; a1 = -1;
    for (int c = 0; c < 20; c++) begin
      @(posedge clk); #1;
      if (act_ok) begin
        cmd_valid = 1'b1; cmd = 2'd0;
        if (a0 < 0) a0 = c; else if (a1 < 0) a1 = c;
      end else if (pre_ok) begin
        cmd_valid = 1'b1; cmd = 2'd3;
        if (p0 < 0) p0 = c;
      end else cmd_valid = 1'b0;
    end
    chk("R4 act to pre gap", p0 - a0, 3);
    chk("R6 pre to act gap", a1 - p0, 3);
    chk("R7 act to act gap", a1 - a0, 6);

    // R3 R9: latency 3 train on a fresh bank
    drive(1'b0, 2'd0, '0);
    rst_ni = 1'b0;
    @(posedge clk); #1 rst_ni = 1'b1;
    cl = 4'd3;
    drive(1'b1, 2'd0, 8'hA5);
    drive(1'b0, 2'd0, '0);
    @(negedge clk);
    chk("R9 open after act", bopen, 1);
    chk("R9 row after act", orow, 8'hA5);
    drive(1'b1, 2'd1, '0);
    @(negedge clk);
    chk("R2 read allowed at trcd", rd_ok, 1);
    first_v = -1; run = 0;
    for (int k = 1; k <= 10; k++) begin
      drive(1'b0, 2'd0, '0);
      @(negedge clk);
      if (rdv) begin
        run++;
        if (first_v < 0) first_v = k;
      end
    end
    chk("R3 first valid offset", first_v, 3);
    chk("R3 burst length", run, BL);
    summary();
  end
endmodule